// File: doc/BRIEF.md
# Four-Event Timestamp Capture Unit

This block measures the timing of one digital input against a free-running time base. A counter advances once per clock. Qualified edges of the input copy the count into one of four capture slots. A two-bit event pointer picks the slot and visits the slots in a fixed order. Each event slot has its own edge polarity and its own option to clear the time base, so the block can give absolute timestamps or, by clearing the counter on events, the interval since the last event. An optional prescaler divides the input before edges are selected.

The sequence runs in one of two modes. In one-shot mode it stops after a programmed event and stays frozen until software re-arms it. In continuous mode it wraps back to the first slot after that event. The time base can also be loaded with a phase value, either from a synchronisation pulse coming from a neighbouring unit or from a software command. A small synchronous register port holds the control word, the phase value, the live count and the four capture values. One-cycle strobes report each capture event and each counter rollover.

Register map, by write/read address: 0 = control, 1 = phase, 2 = live count (read only), 4 to 7 = capture slots 1 to 4 (read only). Control word bits: [0] run, [1] one-shot, [3:2] stop/wrap event index (0 selects event 1, 3 selects event 4), [4] capture-load enable, [5] sync enable, [9:6] polarity of events 1 to 4 (1 = falling edge), [13:10] counter clear on events 1 to 4, [18:14] prescale N, [20] re-arm (action), [21] software sync (action).

Top module: `evt_stamp_cap`

## Requirements
- R1: After reset, the control, phase, count and all four capture registers read 0, and evt_strobe and ovf_strobe are low.
- R2: With run (control bit 0) set, the count rises by exactly 1 per clock. With run clear, the count holds its value.
- R3: When the count rolls over from all ones to 0, ovf_strobe is high for one cycle, in the same cycle in which the count reads 0.
- R4: Control bits [9:6] choose the edge per event: 0 = rising, 1 = falling. For a square wave with high time H and low time L, rising-then-rising events give CAP2 - CAP1 = H + L, and rising-then-falling events give H.
- R5: Successive events load slots 1, 2, 3 and 4 in that order. evt_strobe bit k-1 pulses for one cycle for event k, and at most one strobe bit is high at a time.
- R6: With prescale N (bits [18:14]) non-zero, one qualified rising edge occurs per 2N input rising edges. N = 0 bypasses the prescaler.
- R7: In one-shot mode (bit 1 = 1) the sequence freezes after the event chosen by bits [3:2]. No further strobes or loads occur until a re-arm (bit 20) restarts the sequence at slot 1.
- R8: In continuous mode the pointer returns to slot 1 after the chosen event. Slots beyond it are never written.
- R9: With the clear bit for event k set (bit 9+k), the slot stores the count value from before the clear, and the count reads 0 in the cycle after the event. With every event clearing, a period-P wave stores P - 1.
- R10: With capture-load enable (bit 4) clear, events still pulse their strobes and advance the pointer, but no capture slot changes.
- R11: While sync enable (bit 5) is set, a sync_in pulse or a control write with bit 21 set loads the phase value, and the count reads that value on the next cycle. While sync enable is clear, sync_in has no effect.
- R12: Control bits [18:0] read back as written. The action bits 20 and 21 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_in | input | 1 | Asynchronous signal to be timestamped |
| sync_in | input | 1 | Synchronous one-cycle phase-load pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| evt_strobe | output | 4 | One-cycle pulse per capture event, bit k-1 for event k |
| ovf_strobe | output | 1 | One-cycle pulse on counter rollover |

## Verification
The bench targets four kinds of mistake, each with a visible symptom. If the pointer failed to freeze at the stop event, a third strobe would appear and slot 3 would be overwritten. If it failed to wrap, slot 3 would be written in continuous mode. If the count were cleared before the capture, the interval values would come out one cycle short, or the count would not read 0 just after a clearing event. The bench also checks the prescaler's divide ratio at two settings, a sync pulse that arrives while sync is disabled (it must leave the count untouched), and the exact cycle in which the rollover strobe fires.

// File: rtl/evt_stamp_pkg.sv
// Shared constants and the control-word layout for the timestamp capture unit.
// Assumes a data width of at least 22 bits, so that the action bits fit.
package evt_stamp_pkg;
    localparam int NUM_EVT    = 4;
    localparam int PTR_W      = 2;
    localparam int PRESC_W    = 5;
    localparam int ADDR_W     = 3;
    localparam int CTRL_W     = 19;
    localparam int REARM_BIT  = 20;
    localparam int SWSYNC_BIT = 21;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PHASE = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;

    // Stored control fields; the packed order gives bit 0 = run, up to bits 18:14 = prescale.
    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [NUM_EVT-1:0] rst_en;
        logic [NUM_EVT-1:0] pol;
        logic               sync_en;
        logic               load_en;
        logic [PTR_W-1:0]   stop_wrap;
        logic               oneshot;
        logic               run;
    } ctrl_t;
endpackage

// File: rtl/evt_stamp_cond.sv
// Input conditioner: a two-flop synchronizer, then an optional divide-by-2N
// prescaler, then rise/fall detection on the conditioned signal.
// Assumes cap_in is asynchronous and that presc only changes while cap_in is idle.
module evt_stamp_cond
    import evt_stamp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_in,
    input  logic [PRESC_W-1:0] presc,
    output logic               rise,
    output logic               fall
);
    logic               s1, s2, s3;
    logic [PRESC_W-1:0] pcnt;
    logic               q_reg, q_prev, q_sig;
    logic               in_rise;
    logic               bypass;

    assign in_rise = s2 & ~s3;
    assign bypass  = (presc == '0);
    assign q_sig   = bypass ? s2 : q_reg;
    assign rise    = q_sig & ~q_prev;
    assign fall    = ~q_sig & q_prev;

    // Bring the asynchronous input into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= cap_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Toggle the divided signal once every N synchronized rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt  <= '0;
            q_reg <= 1'b0;
        end else if (bypass) begin
            pcnt  <= '0;
            q_reg <= s2;
        end else if (in_rise) begin
            if (pcnt >= presc - PRESC_W'(1)) begin
                pcnt  <= '0;
                q_reg <= ~q_reg;
            end else begin
                pcnt <= pcnt + PRESC_W'(1);
            end
        end
    end

    // Remember the previous conditioned level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) q_prev <= 1'b0;
        else        q_prev <= q_sig;
    end
endmodule

// File: rtl/evt_stamp_seq.sv
// Event sequencer: a mod-4 pointer that applies the polarity of the current
// event, stops (one-shot) or wraps (continuous) at the stop/wrap index, and
// restarts on re-arm. Assumes rearm is a single-cycle pulse.
module evt_stamp_seq
    import evt_stamp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise,
    input  logic               fall,
    input  logic [NUM_EVT-1:0] pol,
    input  logic               oneshot,
    input  logic [PTR_W-1:0]   stop_wrap,
    input  logic               rearm,
    output logic               evt_valid,
    output logic [PTR_W-1:0]   evt_idx,
    output logic               frozen
);
    logic [PTR_W-1:0] ptr;
    logic             frz;
    logic             hit;

    assign hit       = pol[ptr] ? fall : rise;
    assign evt_valid = hit & ~frz;
    assign evt_idx   = ptr;
    assign frozen    = frz;

    // Advance, wrap or freeze the pointer on each accepted event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            frz <= 1'b0;
        end else if (rearm) begin
            ptr <= '0;
            frz <= 1'b0;
        end else if (evt_valid) begin
            if (ptr == stop_wrap) begin
                if (oneshot) frz <= 1'b1;
                else         ptr <= '0;
            end else begin
                ptr <= ptr + PTR_W'(1);
            end
        end
    end
endmodule

// File: rtl/evt_stamp_tbase.sv
// Time base: a free-running counter with phase load (highest priority),
// clear on event, and run/freeze. It pulses ovf for one cycle on rollover.
module evt_stamp_tbase #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] phase,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    // Update the count and flag the rollover from all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (load) begin
                count <= phase;
            end else if (clr) begin
                count <= '0;
            end else if (run) begin
                count <= count + CNT_W'(1);
                ovf   <= &count;
            end
        end
    end
endmodule

// File: rtl/evt_stamp_cap.sv
// Four-event timestamp capture unit, top level. It holds the control and phase
// registers and the four capture slots, and drives the read mux and the strobes.
// Assumes CNT_W >= 22 and a single synchronous clock domain apart from cap_in.
module evt_stamp_cap
    import evt_stamp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_in,
    input  logic              sync_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [NUM_EVT-1:0] evt_strobe,
    output logic              ovf_strobe
);
    ctrl_t              ctrl_q;
    logic [CNT_W-1:0]   phase_q;
    logic [CNT_W-1:0]   cap_q [NUM_EVT];
    logic [CNT_W-1:0]   count;
    logic               rise, fall;
    logic               evt_valid;
    logic [PTR_W-1:0]   evt_idx;
    logic               frozen;
    logic               wr_ctrl, rearm, sw_sync, sync_load, clr;
    logic               unused_hi;

    assign unused_hi = &{1'b0, wr_data[CNT_W-1:SWSYNC_BIT+1], wr_data[CTRL_W]};
    assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
    assign rearm     = wr_ctrl && wr_data[REARM_BIT];
    assign sw_sync   = wr_ctrl && wr_data[SWSYNC_BIT];
    assign sync_load = ctrl_q.sync_en && (sync_in || sw_sync);
    assign clr       = evt_valid && ctrl_q.rst_en[evt_idx];

    evt_stamp_cond u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_in (cap_in),
        .presc  (ctrl_q.presc),
        .rise   (rise),
        .fall   (fall)
    );

    evt_stamp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .fall      (fall),
        .pol       (ctrl_q.pol),
        .oneshot   (ctrl_q.oneshot),
        .stop_wrap (ctrl_q.stop_wrap),
        .rearm     (rearm),
        .evt_valid (evt_valid),
        .evt_idx   (evt_idx),
        .frozen    (frozen)
    );

    evt_stamp_tbase #(.CNT_W(CNT_W)) u_tbase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q.run),
        .load  (sync_load),
        .phase (phase_q),
        .clr   (clr),
        .count (count),
        .ovf   (ovf_strobe)
    );

    // Hold the control and phase registers written through the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            phase_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL)  ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_addr == A_PHASE) phase_q <= wr_data;
        end
    end

    // Copy the pre-update count into the slot the pointer selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_EVT; k++) cap_q[k] <= '0;
        end else if (evt_valid && ctrl_q.load_en) begin
            for (int k = 0; k < NUM_EVT; k++)
                if (evt_idx == PTR_W'(k)) cap_q[k] <= count;
        end
    end

    // Pulse the strobe bit of the event that just occurred.
    always_ff @(posedge clk) begin
        if (!rst_n)         evt_strobe <= '0;
        else if (evt_valid) evt_strobe <= NUM_EVT'(1) << evt_idx;
        else                evt_strobe <= '0;
    end

    // Select register contents for the read port.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data[CTRL_W-1:0] = ctrl_q;
            A_PHASE: rd_data = phase_q;
            A_COUNT: rd_data = count;
            default: if (rd_addr[2]) rd_data = cap_q[rd_addr[1:0]];
        endcase
    end
endmodule

// File: rtl/evt_stamp_chk.sv
// Property checker for evt_stamp_cap, attached to every instance with bind.
module evt_stamp_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             sync_load,
    input logic [CNT_W-1:0] phase,
    input logic             clr,
    input logic [CNT_W-1:0] count,
    input logic             ovf,
    input logic [3:0]       evt_strobe,
    input logic             frozen,
    input logic             rearm
);
    p_hold_when_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !sync_load && !clr) |=> (count == $past(count)));

    p_ovf_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (count == '0));

    p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_strobe));

    p_frozen_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !rearm) |=> (evt_strobe == '0));

    p_clear_to_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !sync_load) |=> (count == '0));

    p_phase_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sync_load |=> (count == $past(phase)));
endmodule

bind evt_stamp_cap evt_stamp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl_q.run),
    .sync_load  (sync_load),
    .phase      (phase_q),
    .clr        (clr),
    .count      (count),
    .ovf        (ovf_strobe),
    .evt_strobe (evt_strobe),
    .frozen     (frozen),
    .rearm      (rearm)
);

// File: tb/evt_stamp_cap_bench.sv
// Self-checking bench for evt_stamp_cap: a vector table for edge timing, then directed tests.
module evt_stamp_cap_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_in = 1'b0;
    logic        sync_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  evt_strobe;
    logic        ovf_strobe;

    int nchecks = 0;
    int nfail   = 0;
    int scnt [4];
    int ocnt = 0;

    localparam logic [2:0] RA_CTRL = 3'd0, RA_PHASE = 3'd1, RA_COUNT = 3'd2;
    localparam logic [2:0] RA_C1 = 3'd4, RA_C2 = 3'd5, RA_C3 = 3'd6, RA_C4 = 3'd7;

    // Vectors: high time, low time, polarity of event 2 (1 = falling).
    localparam int NVEC = 6;
    localparam int VEC [0:NVEC-1][0:2] = '{
        '{3, 5, 0}, '{4, 4, 1}, '{7, 2, 0}, '{6, 3, 1}, '{1, 1, 0}, '{10, 10, 1}
    };

    always #5 clk = ~clk;

    evt_stamp_cap u_evt_stamp_cap (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .sync_in(sync_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_strobe(evt_strobe), .ovf_strobe(ovf_strobe)
    );

    initial for (int k = 0; k < 4; k++) scnt[k] = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 4; k++) if (evt_strobe[k]) scnt[k] = scnt[k] + 1;
            if (ovf_strobe) ocnt = ocnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic run, input logic os, input logic [1:0] sw,
                                       input logic ld, input logic se, input logic [3:0] pol,
                                       input logic [3:0] rst, input logic [4:0] n,
                                       input logic ra, input logic ss);
        return {10'd0, ss, ra, 1'b0, n, rst, pol, se, ld, sw, os, run};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wave(input int h, input int l, input int n);
        @(negedge clk);
        repeat (n) begin
            cap_in = 1'b1;
            repeat (h) @(negedge clk);
            cap_in = 1'b0;
            repeat (l) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v0, v1, v2, v3, c3old, c1old;
        int s0, s1, s2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(RA_CTRL, v0);  chk("R1 ctrl", v0, 0);
        rd(RA_PHASE, v0); chk("R1 phase", v0, 0);
        rd(RA_COUNT, v0); chk("R1 count", v0, 0);
        for (int a = 4; a < 8; a++) begin rd(3'(a), v0); chk("R1 cap", v0, 0); end
        chk("R1 strobes", {27'd0, evt_strobe, ovf_strobe}, 0);

        // R12: control readback, action bits read 0
        wr(RA_CTRL, 32'h003F_FFFF);
        rd(RA_CTRL, v0); chk("R12 ctrl readback", v0, 32'h0007_FFFF);
        wr(RA_PHASE, 32'hA5A5_1234);
        rd(RA_PHASE, v0); chk("R12 phase readback", v0, 32'hA5A5_1234);
        wr(RA_PHASE, 32'h0);
        wr(RA_CTRL, mk(0, 0, 0, 0, 0, 4'h0, 4'h0, 0, 1, 0));

        // R2: run/freeze
        rd(RA_COUNT, v0); idle(5); rd(RA_COUNT, v1);
        chk("R2 frozen count holds", v1, v0);
        wr(RA_CTRL, mk(1, 0, 0, 0, 0, 4'h0, 4'h0, 0, 0, 0));
        rd(RA_COUNT, v0); repeat (4) @(negedge clk); rd(RA_COUNT, v1);
        chk("R2 count +5 in 5 clocks", v1 - v0, 5);

        // R4: table of edge-timing vectors (one-shot, stop after event 2)
        for (int i = 0; i < NVEC; i++) begin
            wr(RA_CTRL, mk(1, 1, 2'd1, 1, 0, {2'b00, VEC[i][2][0], 1'b0}, 4'h0, 0, 1, 0));
            wave(VEC[i][0], VEC[i][1], 3);
            idle(8);
            rd(RA_C1, v0); rd(RA_C2, v1);
            chk("R4 cap2-cap1", v1 - v0, 32'((VEC[i][2] != 0) ? VEC[i][0] : VEC[i][0] + VEC[i][1]));
        end

        // R5: four events in order, one-shot stop after event 4
        s0 = scnt[3];
        wr(RA_CTRL, mk(1, 1, 2'd3, 1, 0, 4'h0, 4'h0, 0, 1, 0));
        wave(5, 5, 5); idle(8);
        rd(RA_C1, v0); rd(RA_C2, v1); rd(RA_C3, v2); rd(RA_C4, v3);
        chk("R5 cap2-cap1", v1 - v0, 10);
        chk("R5 cap3-cap2", v2 - v1, 10);
        chk("R5 cap4-cap3", v3 - v2, 10);
        chk("R5 event4 strobes", 32'(scnt[3] - s0), 1);

        // R7: one-shot freezes after event 2, re-arm restarts at slot 1
        rd(RA_C3, c3old);
        s0 = scnt[0]; s1 = scnt[1]; s2 = scnt[2];
        wr(RA_CTRL, mk(1, 1, 2'd1, 1, 0, 4'h0, 4'h0, 0, 1, 0));
        wave(4, 4, 4); idle(8);
        chk("R7 event1 strobes", 32'(scnt[0] - s0), 1);
        chk("R7 event2 strobes", 32'(scnt[1] - s1), 1);
        chk("R7 event3 strobes", 32'(scnt[2] - s2), 0);
        rd(RA_C3, v2); chk("R7 cap3 untouched", v2, c3old);
        rd(RA_C1, c1old); rd(RA_C2, v1); chk("R7 cap2-cap1", v1 - c1old, 8);
        wr(RA_CTRL, mk(1, 1, 2'd1, 1, 0, 4'h0, 4'h0, 0, 1, 0));
        wave(4, 4, 1); idle(8);
        chk("R7 rearm event1 strobes", 32'(scnt[0] - s0), 2);
        rd(RA_C1, v0); chk("R7 rearm reloads cap1", 32'(v0 != c1old), 1);

        // R8: continuous wrap after event 2
        s0 = scnt[0]; s1 = scnt[1]; s2 = scnt[2];
        wr(RA_CTRL, mk(1, 0, 2'd1, 1, 0, 4'h0, 4'h0, 0, 1, 0));
        wave(4, 4, 5); idle(8);
        chk("R8 event1 strobes", 32'(scnt[0] - s0), 3);
        chk("R8 event2 strobes", 32'(scnt[1] - s1), 2);
        chk("R8 event3 strobes", 32'(scnt[2] - s2), 0);
        rd(RA_C1, v0); rd(RA_C2, v1); chk("R8 cap1-cap2", v0 - v1, 8);
        rd(RA_C3, v2); chk("R8 cap3 untouched", v2, c3old);

        // R9: clear on every event 1, wrap after event 1
        wr(RA_CTRL, mk(1, 0, 2'd0, 1, 0, 4'h0, 4'h1, 0, 1, 0));
        rd_addr = RA_COUNT;
        fork
            wave(6, 6, 4);
            begin
                do @(negedge clk); while (!evt_strobe[0]);
                #1 chk("R9 count zero after event", rd_data, 0);
            end
        join
        idle(8);
        rd(RA_C1, v0); chk("R9 interval value", v0, 11);

        // R10: load disabled: strobes only
        rd(RA_C1, v0);
        s0 = scnt[0]; s1 = scnt[1];
        wr(RA_CTRL, mk(1, 0, 2'd3, 0, 0, 4'h0, 4'h0, 0, 1, 0));
        wave(5, 5, 3); idle(8);
        chk("R10 event1 strobes", 32'(scnt[0] - s0), 1);
        chk("R10 event2 strobes", 32'(scnt[1] - s1), 1);
        rd(RA_C1, v1); chk("R10 cap1 unchanged", v1, v0);
        rd(RA_C3, v2); chk("R10 cap3 unchanged", v2, c3old);

        // R6: prescaler divide by 2N
        wr(RA_CTRL, mk(1, 1, 2'd1, 1, 0, 4'h0, 4'h0, 5'd1, 1, 0));
        wave(5, 5, 6); idle(10);
        rd(RA_C1, v0); rd(RA_C2, v1); chk("R6 N=1 interval", v1 - v0, 20);
        wr(RA_CTRL, mk(1, 1, 2'd1, 1, 0, 4'h0, 4'h0, 5'd2, 1, 0));
        wave(5, 5, 10); idle(10);
        rd(RA_C1, v0); rd(RA_C2, v1); chk("R6 N=2 interval", v1 - v0, 40);
        wr(RA_CTRL, mk(1, 0, 0, 0, 0, 4'h0, 4'h0, 0, 0, 0));
        idle(4);

        // R11: phase load from sync_in and software, ignored when disabled
        wr(RA_CTRL, mk(1, 0, 0, 0, 1, 4'h0, 4'h0, 0, 0, 0));
        wr(RA_PHASE, 32'h0000_1000);
        rd_addr = RA_COUNT;
        @(negedge clk); sync_in = 1'b1;
        @(negedge clk); sync_in = 1'b0;
        #1 chk("R11 sync_in load", rd_data, 32'h0000_1000);
        wr(RA_PHASE, 32'h0000_2000);
        wr(RA_CTRL, mk(1, 0, 0, 0, 1, 4'h0, 4'h0, 0, 0, 1));
        #1 chk("R11 software sync load", rd_data, 32'h0000_2000);
        wr(RA_CTRL, mk(1, 0, 0, 0, 0, 4'h0, 4'h0, 0, 0, 0));
        @(negedge clk); #1 v0 = rd_data; sync_in = 1'b1;
        @(negedge clk); sync_in = 1'b0;
        #1 chk("R11 sync ignored when disabled", rd_data, v0 + 1);

        // R3: rollover strobe timing
        wr(RA_CTRL, mk(1, 0, 0, 0, 1, 4'h0, 4'h0, 0, 0, 0));
        wr(RA_PHASE, 32'hFFFF_FFFD);
        s0 = ocnt;
        wr(RA_CTRL, mk(1, 0, 0, 0, 1, 4'h0, 4'h0, 0, 0, 1));
        rd_addr = RA_COUNT;
        #1 chk("R3 loaded near max", rd_data, 32'hFFFF_FFFD);
        @(negedge clk); #1 chk("R3 no early ovf", {31'd0, ovf_strobe}, 0);
        @(negedge clk);
        @(negedge clk); #1;
        chk("R3 ovf strobe at wrap", {31'd0, ovf_strobe}, 1);
        chk("R3 count zero at wrap", rd_data, 0);
        idle(6);
        chk("R3 single ovf pulse", 32'(ocnt - s0), 1);

        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end
endmodule